// File: doc/BRIEF.md
# Single-Bit Line/Column Parity Checker with Byte Repair

This block judges a 512-byte data chunk by comparing two 24-bit line/column parity codes: one read back from storage with the chunk, and one recomputed while the chunk was read. The recomputed code arrives as the raw 32-bit value of a parity engine. In that value the two 12-bit parity halves sit in separate half-words. The block packs the halves into a 24-bit code and inverts it, so that a fully erased chunk (all ones) matches an erased stored code. A one-cycle start strobe launches a comparison. One cycle later the block reports one of three outcomes: clean, corrected or uncorrectable. For a data error it also reports the byte index and the bit position to flip.

When the repair path is built in (`FIX_EN = 1`), a repairable data error is also fixed in an attached byte buffer. The block reads the byte, XORs in the single-bit mask and writes it back, then pulses a done flag. While that sequence runs, the block reports busy and ignores new start strobes. A single-bit difference means the fault lies in the stored code itself. That case is reported as corrected and leaves the buffer untouched.

Top module: `ecc1_checker`

## Requirements
- R1: The recomputed code is the bitwise inverse of {raw[27:16], raw[11:0]}. Raw bits 31:28 and 15:12 have no effect. A raw value of zero against a stored code of 0xFFFFFF is clean.
- R2: After reset, res_valid, busy, fix_done, buf_rd_en, buf_wr_en and res_status are 0. res_valid is 1 exactly in the cycle after an accepted start (start high while busy is low), and 0 at all other times.
- R3: A zero difference (recomputed XOR stored) gives res_status 0 (clean), res_in_data 0, res_byte 0 and res_bit 0.
- R4: Take the difference d. If d[23:12] XOR d[11:0] equals 0xFFF and d[23:15] is below CHUNK_BYTES, the result is res_status 1 (corrected) with res_in_data 1, res_byte = d[23:15] and res_bit = d[14:12].
- R5: If the R4 pattern holds but d[23:15] is not below CHUNK_BYTES, res_status is 2 (uncorrectable).
- R6: A difference with exactly one set bit gives res_status 1 with res_in_data 0, res_byte 0 and res_bit 0.
- R7: Any other nonzero difference gives res_status 2, res_in_data 0, res_byte 0 and res_bit 0.
- R8: With FIX_EN = 1, an R4 result starts a repair. In the cycle after start, buf_rd_en is 1 and buf_addr is the byte index. In the next cycle, buf_wr_en is 1 and buf_wdata is buf_rdata XOR (1 << bit). In the cycle after that, fix_done is 1. busy is 1 from the read cycle through the done cycle. The buffer returns read data one cycle after buf_rd_en.
- R9: A start strobe while busy is 1 is ignored. res_valid stays 0 and the previous result stays on the result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Compare strobe, one cycle |
| calc_raw | input | 32 | Raw recomputed parity value (halves at 11:0 and 27:16) |
| stored_code | input | 24 | Stored code, byte k at bits 8k+7:8k, least significant byte first |
| res_valid | output | 1 | Result valid pulse |
| res_status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| res_in_data | output | 1 | 1 when the corrected error lies in the data |
| res_byte | output | 9 | Byte index to flip |
| res_bit | output | 3 | Bit position to flip |
| busy | output | 1 | Repair sequence in progress |
| buf_addr | output | 9 | Buffer byte address |
| buf_rd_en | output | 1 | Buffer read request |
| buf_rdata | input | 8 | Buffer read data, one cycle after buf_rd_en |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Repaired byte |
| fix_done | output | 1 | Repair complete pulse |

## Verification
The out-of-range index case cannot arise at the default size. A 9-bit index always addresses a 512-byte chunk, so the bench adds a second instance with a 320-byte chunk and compares both instances on the same stimulus. Random 24-bit differences almost never meet the complementary-halves pattern. The bench therefore builds repairable differences from a random byte and bit. A start strobe is also driven in the middle of a repair, so the bench can show that it is dropped.

// File: rtl/ecc1_pkg.sv
package ecc1_pkg;
  localparam int BYTE_W = 8;
  localparam int BITPOS_W = 3;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_BAD   = 2'd2
  } ecc_status_e;

  typedef enum logic [1:0] {
    FX_IDLE,
    FX_READ,
    FX_WRITE,
    FX_DONE
  } fix_state_e;
endpackage

// File: rtl/ecc1_pack.sv
module ecc1_pack #(
  parameter int RAW_W  = 32,
  parameter int HALF_W = 12
) (
  input  logic [RAW_W-1:0]    raw,
  output logic [2*HALF_W-1:0] code
);
  localparam int UP_LSB = RAW_W / 2;

  // lower half -> code low half, upper half-word field -> code high half, inverted
  assign code = ~{raw[UP_LSB +: HALF_W], raw[HALF_W-1:0]};

  logic unused_bits;
  assign unused_bits = ^{raw[RAW_W-1:UP_LSB+HALF_W], raw[UP_LSB-1:HALF_W]};
endmodule

// File: rtl/ecc1_classify.sv
module ecc1_classify
  import ecc1_pkg::*;
#(
  parameter int HALF_W      = 12,
  parameter int CHUNK_BYTES = 512
) (
  input  logic [2*HALF_W-1:0]  calc_code,
  input  logic [2*HALF_W-1:0]  stored_code,
  output ecc_status_e          status,
  output logic                 in_data,
  output logic [HALF_W-4:0]    byte_idx,
  output logic [BITPOS_W-1:0]  bit_pos
);
  localparam int CODE_W = 2 * HALF_W;
  localparam int IDX_W  = HALF_W - 3;
  localparam logic [IDX_W:0] LIMIT = (IDX_W + 1)'(CHUNK_BYTES);

  logic [CODE_W-1:0] diff;
  logic [HALF_W-1:0] fold;
  logic [IDX_W-1:0]  idx;

  assign diff = calc_code ^ stored_code;
  assign fold = diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0];
  assign idx  = diff[CODE_W-1:HALF_W+BITPOS_W];

  always_comb begin
    status   = ST_CLEAN;
    in_data  = 1'b0;
    byte_idx = '0;
    bit_pos  = '0;
    if (diff != '0) begin
      if (&fold) begin
        if ({1'b0, idx} < LIMIT) begin
          status   = ST_FIXED;
          in_data  = 1'b1;
          byte_idx = idx;
          bit_pos  = diff[HALF_W+BITPOS_W-1:HALF_W];
        end else begin
          status = ST_BAD;
        end
      end else if ($onehot(diff)) begin
        status = ST_FIXED;  // fault sits in the code, data untouched
      end else begin
        status = ST_BAD;
      end
    end
  end
endmodule

// File: rtl/ecc1_fixer.sv
module ecc1_fixer
  import ecc1_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                launch,
  input  logic [ADDR_W-1:0]   byte_idx,
  input  logic [BITPOS_W-1:0] bit_pos,
  output logic                busy,
  output logic [ADDR_W-1:0]   buf_addr,
  output logic                buf_rd_en,
  input  logic [BYTE_W-1:0]   buf_rdata,
  output logic                buf_wr_en,
  output logic [BYTE_W-1:0]   buf_wdata,
  output logic                fix_done
);
  fix_state_e        st;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= FX_IDLE;
      addr_q <= '0;
      mask_q <= '0;
    end else begin
      unique case (st)
        FX_IDLE: if (launch) begin
          st     <= FX_READ;
          addr_q <= byte_idx;
          mask_q <= BYTE_W'(1) << bit_pos;
        end
        FX_READ:  st <= FX_WRITE;
        FX_WRITE: st <= FX_DONE;
        default:  st <= FX_IDLE;
      endcase
    end
  end

  assign busy      = (st != FX_IDLE);
  assign buf_addr  = addr_q;
  assign buf_rd_en = (st == FX_READ);
  assign buf_wr_en = (st == FX_WRITE);
  assign buf_wdata = buf_rdata ^ mask_q;
  assign fix_done  = (st == FX_DONE);
endmodule

// File: rtl/ecc1_checker.sv
module ecc1_checker
  import ecc1_pkg::*;
#(
  parameter int RAW_W       = 32,
  parameter int HALF_W      = 12,
  parameter int CHUNK_BYTES = 512,
  parameter bit FIX_EN      = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [RAW_W-1:0]       calc_raw,
  input  logic [2*HALF_W-1:0]    stored_code,
  output logic                   res_valid,
  output logic [1:0]             res_status,
  output logic                   res_in_data,
  output logic [HALF_W-4:0]      res_byte,
  output logic [BITPOS_W-1:0]    res_bit,
  output logic                   busy,
  output logic [HALF_W-4:0]      buf_addr,
  output logic                   buf_rd_en,
  input  logic [BYTE_W-1:0]      buf_rdata,
  output logic                   buf_wr_en,
  output logic [BYTE_W-1:0]      buf_wdata,
  output logic                   fix_done
);
  localparam int CODE_W = 2 * HALF_W;
  localparam int IDX_W  = HALF_W - 3;

  logic [CODE_W-1:0]   calc_code;
  ecc_status_e         cls_status;
  logic                cls_in_data;
  logic [IDX_W-1:0]    cls_byte;
  logic [BITPOS_W-1:0] cls_bit;
  logic                accept;

  ecc1_pack #(.RAW_W(RAW_W), .HALF_W(HALF_W)) u_pack (
    .raw(calc_raw), .code(calc_code)
  );

  ecc1_classify #(.HALF_W(HALF_W), .CHUNK_BYTES(CHUNK_BYTES)) u_cls (
    .calc_code(calc_code), .stored_code(stored_code), .status(cls_status),
    .in_data(cls_in_data), .byte_idx(cls_byte), .bit_pos(cls_bit)
  );

  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_status  <= ST_CLEAN;
      res_in_data <= 1'b0;
      res_byte    <= '0;
      res_bit     <= '0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        res_status  <= cls_status;
        res_in_data <= cls_in_data;
        res_byte    <= cls_byte;
        res_bit     <= cls_bit;
      end
    end
  end

  generate
    if (FIX_EN) begin : g_fix
      ecc1_fixer #(.ADDR_W(IDX_W)) u_fix (
        .clk(clk), .rst(rst), .launch(accept && cls_in_data),
        .byte_idx(cls_byte), .bit_pos(cls_bit), .busy(busy),
        .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata),
        .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata), .fix_done(fix_done)
      );
    end else begin : g_nofix
      logic unused_rdata;
      assign unused_rdata = ^buf_rdata;
      assign busy      = 1'b0;
      assign buf_addr  = '0;
      assign buf_rd_en = 1'b0;
      assign buf_wr_en = 1'b0;
      assign buf_wdata = '0;
      assign fix_done  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ecc1_checker_sva.sv
module ecc1_checker_sva (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       res_valid,
  input logic [1:0] res_status,
  input logic       res_in_data,
  input logic [8:0] res_byte,
  input logic [2:0] res_bit,
  input logic       buf_rd_en,
  input logic       buf_wr_en,
  input logic       fix_done
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> res_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(start && !busy));

  a_r9_busy_drops_start: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> (!res_valid && $stable(res_status)));

  a_r3_clean_zeroes: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status == 2'd0) |-> (!res_in_data && res_byte == 9'd0 && res_bit == 3'd0));

  a_r7_bad_no_data: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status == 2'd2) |-> !res_in_data);

  a_r8_read_then_write: assert property (@(posedge clk) disable iff (rst)
    buf_rd_en |=> buf_wr_en);

  a_r8_write_then_done: assert property (@(posedge clk) disable iff (rst)
    buf_wr_en |=> fix_done);

  a_r8_read_on_result: assert property (@(posedge clk) disable iff (rst)
    buf_rd_en |-> (res_valid && res_in_data && busy));

  a_r8_one_access: assert property (@(posedge clk) disable iff (rst)
    $onehot0({buf_rd_en, buf_wr_en, fix_done}));
endmodule

bind ecc1_checker ecc1_checker_sva u_sva (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .res_valid(res_valid), .res_status(res_status), .res_in_data(res_in_data),
  .res_byte(res_byte), .res_bit(res_bit), .buf_rd_en(buf_rd_en),
  .buf_wr_en(buf_wr_en), .fix_done(fix_done)
);

// File: tb/ecc1_checker_test.sv
module ecc1_checker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] calc_raw = '0;
  logic [23:0] stored_code = '0;
  logic        res_valid, res_in_data, busy, buf_rd_en, buf_wr_en, fix_done;
  logic [1:0]  res_status;
  logic [8:0]  res_byte, buf_addr;
  logic [2:0]  res_bit;
  logic [7:0]  buf_rdata, buf_wdata;

  logic        sm_valid, sm_in_data, sm_busy, sm_rd, sm_wr, sm_done;
  logic [1:0]  sm_status;
  logic [8:0]  sm_byte, sm_addr;
  logic [2:0]  sm_bit;
  logic [7:0]  sm_wdata;

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] mem [512];

  always #10 clk = ~clk;

  ecc1_checker uut (
    .clk(clk), .rst(rst), .start(start), .calc_raw(calc_raw), .stored_code(stored_code),
    .res_valid(res_valid), .res_status(res_status), .res_in_data(res_in_data),
    .res_byte(res_byte), .res_bit(res_bit), .busy(busy), .buf_addr(buf_addr),
    .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata), .buf_wr_en(buf_wr_en),
    .buf_wdata(buf_wdata), .fix_done(fix_done)
  );

  ecc1_checker #(.CHUNK_BYTES(320), .FIX_EN(1'b0)) uut_small (
    .clk(clk), .rst(rst), .start(start), .calc_raw(calc_raw), .stored_code(stored_code),
    .res_valid(sm_valid), .res_status(sm_status), .res_in_data(sm_in_data),
    .res_byte(sm_byte), .res_bit(sm_bit), .busy(sm_busy), .buf_addr(sm_addr),
    .buf_rd_en(sm_rd), .buf_rdata(8'h00), .buf_wr_en(sm_wr),
    .buf_wdata(sm_wdata), .fix_done(sm_done)
  );

  always @(posedge clk) begin
    if (buf_rd_en) buf_rdata <= mem[buf_addr];
    if (buf_wr_en) mem[buf_addr] <= buf_wdata;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [23:0] pack_calc(logic [31:0] raw);
    return ~{raw[27:16], raw[11:0]};
  endfunction

  // {status[1:0], in_data, byte[8:0], bit[2:0]}
  function automatic logic [14:0] expect_of(logic [23:0] d, int limit);
    logic [1:0] s = 2'd0;
    logic f = 1'b0;
    logic [8:0] b = '0;
    logic [2:0] k = '0;
    if (d != 24'd0) begin
      if ((d[23:12] ^ d[11:0]) == 12'hFFF) begin
        if (int'(d[23:15]) < limit) begin
          s = 2'd1; f = 1'b1; b = d[23:15]; k = d[14:12];
        end else s = 2'd2;
      end else if ($countones(d) == 1) s = 2'd1;
      else s = 2'd2;
    end
    return {s, f, b, k};
  endfunction

  task automatic do_op(logic [31:0] raw, logic [23:0] stored);
    logic [23:0] d = pack_calc(raw) ^ stored;
    logic [14:0] e = expect_of(d, 512);
    logic [14:0] es = expect_of(d, 320);
    logic [7:0] old = mem[e[11:3]];
    string tg = (e[14:13] == 2'd0) ? "R3" : (e[12] ? "R4" : ((e[14:13] == 2'd1) ? "R6" : "R7"));
    calc_raw = raw; stored_code = stored; start = 1'b1;
    tick();
    start = 1'b0;
    check("R2 valid", {31'd0, res_valid}, 32'd1);
    check({tg, " status"}, {30'd0, res_status}, {30'd0, e[14:13]});
    check({tg, " in_data/byte/bit"}, {19'd0, res_in_data, res_byte, res_bit}, {19'd0, e[12:0]});
    check((es[14:13] == 2'd2 && e[12]) ? "R5 small status" : "R5 small agrees",
          {30'd0, sm_status}, {30'd0, es[14:13]});
    if (e[12]) begin
      check("R8 read", {22'd0, buf_rd_en, busy, buf_addr}, {22'd0, 1'b1, 1'b1, e[11:3]});
      tick();
      check("R8 write", {23'd0, buf_wr_en, buf_wdata}, {23'd0, 1'b1, old ^ (8'd1 << e[2:0])});
      tick();
      check("R8 done", {30'd0, fix_done, busy}, 32'd3);
      tick();
      check("R8 buffer", {24'd0, mem[e[11:3]]}, {24'd0, old ^ (8'd1 << e[2:0])});
    end else begin
      check("R8 no access", {30'd0, buf_rd_en, busy}, 32'd0);
      tick();
    end
    check("R2 valid drops", {31'd0, res_valid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] raw;
    logic [23:0] c;
    logic [11:0] up;
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 5);
    void'($urandom(32'h1c0ffee5));
    repeat (3) tick();
    rst = 1'b0;
    check("R2 reset", {26'd0, res_valid, busy, fix_done, buf_rd_en, buf_wr_en, 1'b0},
          32'd0);
    check("R2 reset status", {30'd0, res_status}, 32'd0);

    // R1: erased chunk and ignored raw bits
    do_op(32'h0000_0000, 24'hFFFFFF);
    do_op(32'hF000_F000, 24'hFFFFFF);
    raw = 32'h0ABC_0123;
    do_op(raw, 24'hFFFFFF ^ {12'hABC, 12'h123});
    // R4 corners
    raw = $urandom;
    up = {9'd511, 3'd7}; do_op(raw, pack_calc(raw) ^ {up, ~up});
    up = {9'd0, 3'd0};   do_op(raw, pack_calc(raw) ^ {up, ~up});
    // R5 via small chunk, R6 code bit, R7 two bits
    up = {9'd400, 3'd2}; do_op(raw, pack_calc(raw) ^ {up, ~up});
    do_op(raw, pack_calc(raw) ^ 24'h800000);
    do_op(raw, pack_calc(raw) ^ 24'h000003);

    // R9: start during repair is dropped
    raw = 32'h1234_5678; c = pack_calc(raw);
    up = {9'd77, 3'd4};
    calc_raw = raw; stored_code = c ^ {up, ~up}; start = 1'b1;
    tick();
    stored_code = c ^ 24'h000300;
    tick();
    start = 1'b0;
    check("R9 ignored valid", {31'd0, res_valid}, 32'd0);
    check("R9 result held", {30'd0, res_status}, 32'd1);
    check("R9 byte held", {23'd0, res_byte}, 32'd77);
    repeat (3) tick();

    for (int n = 0; n < 400; n++) begin
      raw = $urandom;
      c = pack_calc(raw);
      case ($urandom_range(0, 3))
        0: do_op(raw, c);
        1: begin
          up = {9'($urandom_range(0, 511)), 3'($urandom_range(0, 7))};
          do_op(raw, c ^ {up, ~up});
        end
        2: do_op(raw, c ^ (24'd1 << $urandom_range(0, 23)));
        default: do_op(raw, 24'($urandom));
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule